// File: doc/BRIEF.md
# Parallel Display Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync, a data-enable strobe and the current pixel column and row. Each axis has four programmable segments. A line runs through its visible pixels, then the front porch, then the sync pulse, then the back porch. A frame walks through its lines in the same order. Separate polarity bits invert sync, data-enable and the pixel-clock edge select.

All timing and polarity inputs are a staged copy. They reach the working set only when software arms a load. An armed load transfers on the last pixel of the running frame, or on the next cycle when the generator is idle, and the pending flag then drops by itself. Clearing the enable does not stop the raster at once: the current frame finishes, and the enable status stays high until that frame has ended. A vertical-blank status flag is set when the raster enters the first line after the visible area. It is cleared by writing 1 to the clear input and is gated by an interrupt enable. A synchronous soft reset returns the generator to idle before it is reconfigured.

Top module: `dtg_top`

## Requirements
- R1: After rst_n is released, the block is idle: en_status=0, load_pending=0, vbl_status=0, pix_x=pix_y=0, and hsync, vsync and de are 0.
- R2: While running, pix_x counts 0 to HT-1, where HT = h_active+h_front+h_sync+h_back, and then returns to 0. pix_y advances by one each time pix_x wraps and runs 0 to VT-1, where VT is formed the same way from the vertical fields.
- R3: The de output is active exactly when pix_x < h_active and pix_y < v_active.
- R4: The hsync output is active for h_active+h_front <= pix_x < h_active+h_front+h_sync. The vsync output is active for whole lines with v_active+v_front <= pix_y < v_active+v_front+v_sync.
- R5: Each of hsync, vsync and de is XORed with its own working inversion bit, so while idle each one sits at the value of its inversion bit. The pclk_fall output equals the working clock-edge inversion bit.
- R6: A one-cycle load_arm pulse sets load_pending on the next cycle. Staged values reach the working set only on the last pixel of a frame, or on the next edge when idle, and load_pending then clears. Staged values that are never armed have no effect on the raster.
- R7: When en_req is high while idle, running starts on the next edge at pix_x=0, pix_y=0 and en_status goes to 1.
- R8: When en_req goes low, the frame in progress completes and en_status stays 1 until its last pixel. If en_req is high again before that pixel, the raster continues into the next frame.
- R9: vbl_status is set on the edge where the raster enters pix_y=v_active, pix_x=0, and it stays set until a vbl_clr pulse. A set and a clear in the same cycle leave it set.
- R10: vbl_irq equals vbl_status AND vbl_irq_en.
- R11: soft_rst forces the block idle with counters at 0, clears vbl_status and load_pending, and keeps the working timing set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous return to idle |
| en_req | input | 1 | Run request (level) |
| load_arm | input | 1 | Pulse that arms the transfer of staged values |
| h_active | input | FIELD_W | Staged visible pixels per line |
| h_front | input | FIELD_W | Staged horizontal front porch |
| h_sync | input | FIELD_W | Staged horizontal sync width |
| h_back | input | FIELD_W | Staged horizontal back porch |
| v_active | input | FIELD_W | Staged visible lines per frame |
| v_front | input | FIELD_W | Staged vertical front porch |
| v_sync | input | FIELD_W | Staged vertical sync width |
| v_back | input | FIELD_W | Staged vertical back porch |
| inv_hs | input | 1 | Staged hsync inversion |
| inv_vs | input | 1 | Staged vsync inversion |
| inv_de | input | 1 | Staged data-enable inversion |
| inv_pclk | input | 1 | Staged selection of the falling clock edge for data |
| vbl_irq_en | input | 1 | Vertical-blank interrupt enable |
| vbl_clr | input | 1 | Write-1 clear of vbl_status |
| en_status | output | 1 | High while the raster runs, including a pending stop |
| load_pending | output | 1 | Armed load not yet transferred |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk_fall | output | 1 | Working clock-edge select |
| pix_x | output | FIELD_W+2 | Current column |
| pix_y | output | FIELD_W+2 | Current row |
| vbl_status | output | 1 | Vertical-blank status |
| vbl_irq | output | 1 | Vertical-blank interrupt |

## Verification
With the default combinational output stage, the sync, data-enable and coordinate outputs change on the same edge as the counters. The first running cycle is the one after the edge that samples en_req high. load_pending and vbl_status both settle one edge after the event that causes them, and vbl_irq follows vbl_irq_en within the same cycle. The bench drives every input just after the falling edge and samples 1 ns later, so each check reads the state left by the preceding rising edge. Its model indexes every frame by a cycle count, starting from the first running cycle.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int NUM_SEG  = 4;
   localparam int SEG_ACT  = 0;
   localparam int SEG_FP   = 1;
   localparam int SEG_SYNC = 2;
   localparam int SEG_BP   = 3;
   localparam int NUM_AX   = 2;
   localparam int AX_H     = 0;
   localparam int AX_V     = 1;

   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
      logic pclk;
   } dtg_pol_t;
endpackage

// File: rtl/dtg_axis_cnt.sv
module dtg_axis_cnt import dtg_pkg::*; #(
   parameter int FIELD_W = 12,
   localparam int CW = FIELD_W + 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic step_i,
   input  logic [NUM_SEG-1:0][FIELD_W-1:0] seg_i,
   output logic [CW-1:0] cnt_o,
   output logic last_o,
   output logic active_o,
   output logic sync_o
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] act_end, sync_beg, sync_end, total;

   always_comb begin
      act_end  = CW'(seg_i[SEG_ACT]);
      sync_beg = act_end + CW'(seg_i[SEG_FP]);
      sync_end = sync_beg + CW'(seg_i[SEG_SYNC]);
      total    = sync_end + CW'(seg_i[SEG_BP]);
   end

   assign last_o   = (cnt_q + CW'(1)) >= total;
   assign active_o = cnt_q < act_end;
   assign sync_o   = (cnt_q >= sync_beg) && (cnt_q < sync_end);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= last_o ? '0 : cnt_q + CW'(1);
      end
   end

   // R2: a step at the end of the axis returns it to zero
   a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && last_o && !clr_i) |=> (cnt_q == '0));
   // R2: a step inside the axis advances by one
   a_r2_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !last_o && !clr_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/dtg_shadow.sv
module dtg_shadow import dtg_pkg::*; #(
   parameter int FIELD_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic load_arm_i,
   input  logic run_i,
   input  logic frame_end_i,
   input  logic [NUM_AX-1:0][NUM_SEG-1:0][FIELD_W-1:0] stg_tim_i,
   input  dtg_pol_t stg_pol_i,
   output logic [NUM_AX-1:0][NUM_SEG-1:0][FIELD_W-1:0] work_tim_o,
   output dtg_pol_t work_pol_o,
   output logic pending_o
);
   logic [NUM_AX-1:0][NUM_SEG-1:0][FIELD_W-1:0] work_tim_q;
   dtg_pol_t work_pol_q;
   logic pend_q;
   logic xfer;

   assign xfer = pend_q && !soft_rst && (!run_i || frame_end_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_tim_q <= '0;
         work_pol_q <= '0;
         pend_q     <= 1'b0;
      end else begin
         if (xfer) begin
            work_tim_q <= stg_tim_i;
            work_pol_q <= stg_pol_i;
         end
         pend_q <= soft_rst ? 1'b0 : (load_arm_i || (pend_q && !xfer));
      end
   end

   assign work_tim_o = work_tim_q;
   assign work_pol_o = work_pol_q;
   assign pending_o  = pend_q;

   // R6: the working set never moves inside a running frame
   a_r6_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !frame_end_i) |=> ($stable(work_tim_q) && $stable(work_pol_q)));
   // R6: an armed load while idle is consumed on the next edge
   a_r6_idle_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !run_i && !load_arm_i && !soft_rst) |=> !pend_q);
endmodule

// File: rtl/dtg_vblank.sv
module dtg_vblank (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic status_o,
   output logic irq_o
);
   logic stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
      end else if (soft_rst) begin
         stat_q <= 1'b0;
      end else if (set_i) begin
         stat_q <= 1'b1;
      end else if (clr_i) begin
         stat_q <= 1'b0;
      end
   end

   assign status_o = stat_q;
   assign irq_o    = stat_q && irq_en_i;

   // R9: a set event wins over a clear in the same cycle
   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !soft_rst) |=> stat_q);
   // R9: a clear with no set drops the flag
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !stat_q);
endmodule

// File: rtl/dtg_outstage.sv
module dtg_outstage #(
   parameter int CW = 14,
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_i,
   input  logic vs_i,
   input  logic de_i,
   input  logic [CW-1:0] x_i,
   input  logic [CW-1:0] y_i,
   output logic hs_o,
   output logic vs_o,
   output logic de_o,
   output logic [CW-1:0] x_o,
   output logic [CW-1:0] y_o
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hs_o <= 1'b0;
               vs_o <= 1'b0;
               de_o <= 1'b0;
               x_o  <= '0;
               y_o  <= '0;
            end else begin
               hs_o <= hs_i;
               vs_o <= vs_i;
               de_o <= de_i;
               x_o  <= x_i;
               y_o  <= y_i;
            end
         end
      end else begin : g_comb
         assign hs_o = hs_i;
         assign vs_o = vs_i;
         assign de_o = de_i;
         assign x_o  = x_i;
         assign y_o  = y_i;
      end
   endgenerate
endmodule

// File: rtl/dtg_top.sv
module dtg_top import dtg_pkg::*; #(
   parameter int FIELD_W = 12,
   parameter bit OUT_REG = 1'b0,
   localparam int COORD_W = FIELD_W + 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic en_req,
   input  logic load_arm,
   input  logic [FIELD_W-1:0] h_active,
   input  logic [FIELD_W-1:0] h_front,
   input  logic [FIELD_W-1:0] h_sync,
   input  logic [FIELD_W-1:0] h_back,
   input  logic [FIELD_W-1:0] v_active,
   input  logic [FIELD_W-1:0] v_front,
   input  logic [FIELD_W-1:0] v_sync,
   input  logic [FIELD_W-1:0] v_back,
   input  logic inv_hs,
   input  logic inv_vs,
   input  logic inv_de,
   input  logic inv_pclk,
   input  logic vbl_irq_en,
   input  logic vbl_clr,
   output logic en_status,
   output logic load_pending,
   output logic hsync,
   output logic vsync,
   output logic de,
   output logic pclk_fall,
   output logic [COORD_W-1:0] pix_x,
   output logic [COORD_W-1:0] pix_y,
   output logic vbl_status,
   output logic vbl_irq
);
   generate
      if (FIELD_W < 2) begin : g_bad_width
         $error("dtg_top: FIELD_W must be at least 2");
      end
   endgenerate

   logic [NUM_AX-1:0][NUM_SEG-1:0][FIELD_W-1:0] stg_tim, work_tim;
   dtg_pol_t stg_pol, work_pol;
   logic run_q, frame_end, cnt_clr, vbl_set;
   logic [NUM_AX-1:0] ax_step, ax_last, ax_act, ax_sync;
   logic [NUM_AX-1:0][COORD_W-1:0] ax_cnt;
   logic hs_raw, vs_raw, de_raw, hs_st, vs_st, de_st;

   assign stg_tim[AX_H] = {h_back, h_sync, h_front, h_active};
   assign stg_tim[AX_V] = {v_back, v_sync, v_front, v_active};
   assign stg_pol = '{hs: inv_hs, vs: inv_vs, de: inv_de, pclk: inv_pclk};

   dtg_shadow #(.FIELD_W(FIELD_W)) shadow_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .load_arm_i(load_arm),
      .run_i(run_q), .frame_end_i(frame_end), .stg_tim_i(stg_tim),
      .stg_pol_i(stg_pol), .work_tim_o(work_tim), .work_pol_o(work_pol),
      .pending_o(load_pending));

   assign frame_end = run_q && ax_last[AX_H] && ax_last[AX_V];
   assign cnt_clr   = soft_rst || !run_q;
   assign ax_step[AX_H] = run_q;
   assign ax_step[AX_V] = run_q && ax_last[AX_H];

   generate
      for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
         dtg_axis_cnt #(.FIELD_W(FIELD_W)) cnt_i (
            .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .step_i(ax_step[a]),
            .seg_i(work_tim[a]), .cnt_o(ax_cnt[a]), .last_o(ax_last[a]),
            .active_o(ax_act[a]), .sync_o(ax_sync[a]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (soft_rst) begin
         run_q <= 1'b0;
      end else if (!run_q) begin
         run_q <= en_req;
      end else if (frame_end && !en_req) begin
         run_q <= 1'b0;
      end
   end
   assign en_status = run_q;

   assign vbl_set = run_q && ax_last[AX_H] && !ax_last[AX_V]
                    && ((ax_cnt[AX_V] + COORD_W'(1)) == COORD_W'(work_tim[AX_V][SEG_ACT]));

   dtg_vblank vblank_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .set_i(vbl_set),
      .clr_i(vbl_clr), .irq_en_i(vbl_irq_en), .status_o(vbl_status),
      .irq_o(vbl_irq));

   assign hs_raw = run_q && ax_sync[AX_H];
   assign vs_raw = run_q && ax_sync[AX_V];
   assign de_raw = run_q && ax_act[AX_H] && ax_act[AX_V];

   dtg_outstage #(.CW(COORD_W), .OUT_REG(OUT_REG)) out_i (
      .clk(clk), .rst_n(rst_n), .hs_i(hs_raw), .vs_i(vs_raw), .de_i(de_raw),
      .x_i(ax_cnt[AX_H]), .y_i(ax_cnt[AX_V]), .hs_o(hs_st), .vs_o(vs_st),
      .de_o(de_st), .x_o(pix_x), .y_o(pix_y));

   assign hsync     = hs_st ^ work_pol.hs;
   assign vsync     = vs_st ^ work_pol.vs;
   assign de        = de_st ^ work_pol.de;
   assign pclk_fall = work_pol.pclk;

   // R8: the raster stops only after the last pixel of a frame or on soft reset
   a_r8_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> ($past(frame_end) || $past(soft_rst)));
   // R9: the blank flag rises exactly as the raster enters the first blank line
   a_r9_rise_pos: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vbl_status) |-> (ax_cnt[AX_H] == '0
         && ax_cnt[AX_V] == COORD_W'(work_tim[AX_V][SEG_ACT])));
   // R11: soft reset leaves the raster idle at the origin
   a_r11_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!run_q && ax_cnt[AX_H] == '0 && ax_cnt[AX_V] == '0 && !load_pending));
endmodule

// File: tb/dtg_top_tb_top.sv
module dtg_top_tb_top;
   localparam int W = 12;
   localparam int CW = W + 2;
   localparam time CLK_HALF = 2.5ns;

   typedef struct packed {
      logic [W-1:0] ha, hf, hw, hb, va, vf, vw, vb;
      logic [3:0]   inv; // [3] hs, [2] vs, [1] de, [0] pclk
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{12'd4, 12'd1, 12'd2, 12'd1, 12'd3, 12'd1, 12'd1, 12'd1, 4'b0000},
      '{12'd5, 12'd2, 12'd1, 12'd2, 12'd2, 12'd2, 12'd2, 12'd1, 4'b1100},
      '{12'd3, 12'd1, 12'd1, 12'd1, 12'd2, 12'd1, 12'd1, 12'd1, 4'b0011},
      '{12'd2, 12'd0, 12'd1, 12'd0, 12'd2, 12'd0, 12'd1, 12'd0, 4'b1111}
   };

   logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, en_req = 1'b0, load_arm = 1'b0;
   logic [W-1:0] h_active = '0, h_front = '0, h_sync = '0, h_back = '0;
   logic [W-1:0] v_active = '0, v_front = '0, v_sync = '0, v_back = '0;
   logic inv_hs = 1'b0, inv_vs = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
   logic vbl_irq_en = 1'b1, vbl_clr = 1'b0;
   logic en_status, load_pending, hsync, vsync, de, pclk_fall, vbl_status, vbl_irq;
   logic [CW-1:0] pix_x, pix_y;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_HALF) clk = ~clk;

   dtg_top dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en_req(en_req),
      .load_arm(load_arm), .h_active(h_active), .h_front(h_front),
      .h_sync(h_sync), .h_back(h_back), .v_active(v_active), .v_front(v_front),
      .v_sync(v_sync), .v_back(v_back), .inv_hs(inv_hs), .inv_vs(inv_vs),
      .inv_de(inv_de), .inv_pclk(inv_pclk), .vbl_irq_en(vbl_irq_en),
      .vbl_clr(vbl_clr), .en_status(en_status), .load_pending(load_pending),
      .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
      .pix_x(pix_x), .pix_y(pix_y), .vbl_status(vbl_status), .vbl_irq(vbl_irq));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic apply(input vec_t v);
      h_active = v.ha; h_front = v.hf; h_sync = v.hw; h_back = v.hb;
      v_active = v.va; v_front = v.vf; v_sync = v.vw; v_back = v.vb;
      inv_hs = v.inv[3]; inv_vs = v.inv[2]; inv_de = v.inv[1]; inv_pclk = v.inv[0];
   endtask

   function automatic int htot(input vec_t v);
      return int'(v.ha) + int'(v.hf) + int'(v.hw) + int'(v.hb);
   endfunction

   function automatic int vtot(input vec_t v);
      return int'(v.va) + int'(v.vf) + int'(v.vw) + int'(v.vb);
   endfunction

   task automatic chk_cycle(input vec_t v, input int c);
      int ht, x, y, hs0, vs0;
      ht = htot(v);
      x = c % ht;
      y = c / ht;
      hs0 = int'(v.ha) + int'(v.hf);
      vs0 = int'(v.va) + int'(v.vf);
      chk("R2", "pix_x", int'(pix_x), x);
      chk("R2", "pix_y", int'(pix_y), y);
      chk("R3", "de", int'(de), int'((x < int'(v.ha) && y < int'(v.va)) ^ v.inv[1]));
      chk("R4", "hsync", int'(hsync), int'((x >= hs0 && x < hs0 + int'(v.hw)) ^ v.inv[3]));
      chk("R4", "vsync", int'(vsync), int'((y >= vs0 && y < vs0 + int'(v.vw)) ^ v.inv[2]));
      chk("R7", "en_status running", int'(en_status), 1);
      chk("R9", "vbl_status", int'(vbl_status), int'(y >= int'(v.va)));
      chk("R10", "vbl_irq", int'(vbl_irq), int'(y >= int'(v.va)));
   endtask

   initial begin
      #(CLK_HALF * 2 * 50000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(); tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "en_status", int'(en_status), 0);
      chk("R1", "load_pending", int'(load_pending), 0);
      chk("R1", "vbl_status", int'(vbl_status), 0);
      chk("R1", "pix_x", int'(pix_x), 0);
      chk("R1", "pix_y", int'(pix_y), 0);
      chk("R1", "hsync", int'(hsync), 0);
      chk("R1", "vsync", int'(vsync), 0);
      chk("R1", "de", int'(de), 0);

      // table walk: one full frame per timing vector with a deferred stop
      for (int i = 0; i < 4; i++) begin
         vec_t v;
         v = VECS[i];
         soft_rst = 1'b1;
         tick();
         soft_rst = 1'b0;
         apply(v);
         load_arm = 1'b1;
         tick();
         load_arm = 1'b0;
         chk("R6", "pending after arm", int'(load_pending), 1);
         tick();
         chk("R6", "pending after idle transfer", int'(load_pending), 0);
         chk("R5", "idle hsync level", int'(hsync), int'(v.inv[3]));
         chk("R5", "idle vsync level", int'(vsync), int'(v.inv[2]));
         chk("R5", "idle de level", int'(de), int'(v.inv[1]));
         chk("R5", "pclk_fall", int'(pclk_fall), int'(v.inv[0]));
         chk("R7", "en_status idle", int'(en_status), 0);
         en_req = 1'b1;
         tick();
         en_req = 1'b0;
         for (int c = 0; c < htot(v) * vtot(v); c++) begin
            chk_cycle(v, c);
            tick();
         end
         chk("R8", "en_status after frame", int'(en_status), 0);
         chk("R8", "pix_x after stop", int'(pix_x), 0);
         chk("R8", "pix_y after stop", int'(pix_y), 0);
         chk("R8", "de after stop", int'(de), int'(v.inv[1]));
      end

      // R6: unarmed staged values are ignored, an armed load waits for the frame end
      apply(VECS[0]);
      en_req = 1'b1;
      tick();
      for (int c = 0; c < 9; c++) begin
         chk("R6", "old pix_x", int'(pix_x), c % 3);
         chk("R6", "old pix_y", int'(pix_y), c / 3);
         if (c >= 2) chk("R6", "pending mid frame", int'(load_pending), 1);
         if (c == 1) load_arm = 1'b1;
         if (c == 2) load_arm = 1'b0;
         tick();
      end
      // R8: dropping and restoring en_req inside a frame keeps the raster going
      for (int c = 0; c < 48; c++) begin
         chk("R6", "new pix_x", int'(pix_x), c % 8);
         chk("R6", "new pix_y", int'(pix_y), c / 8);
         if (c == 0) chk("R6", "pending after frame end", int'(load_pending), 0);
         if (c == 2) en_req = 1'b0;
         if (c == 5) en_req = 1'b1;
         tick();
      end
      chk("R8", "en_status after cancel", int'(en_status), 1);
      chk("R8", "pix_x next frame", int'(pix_x), 0);
      chk("R8", "pix_y next frame", int'(pix_y), 0);
      en_req = 1'b0;
      for (int c = 0; c < 41; c++) begin
         if (c == 23) vbl_clr = 1'b1;
         if (c == 24) begin
            vbl_clr = 1'b0;
            chk("R9", "set wins over clear", int'(vbl_status), 1);
         end
         if (c == 25) begin
            vbl_irq_en = 1'b0;
            #1;
            chk("R10", "irq masked", int'(vbl_irq), 0);
            vbl_irq_en = 1'b1;
            #1;
            chk("R10", "irq unmasked", int'(vbl_irq), 1);
         end
         if (c == 40) load_arm = 1'b1;
         tick();
      end
      load_arm = 1'b0;
      chk("R6", "pending before soft reset", int'(load_pending), 1);
      soft_rst = 1'b1;
      tick();
      soft_rst = 1'b0;
      chk("R11", "en_status", int'(en_status), 0);
      chk("R11", "pix_x", int'(pix_x), 0);
      chk("R11", "pix_y", int'(pix_y), 0);
      chk("R11", "vbl_status", int'(vbl_status), 0);
      chk("R11", "load_pending", int'(load_pending), 0);

      // R11: working timing survives soft reset; R9 clear
      en_req = 1'b1;
      tick();
      en_req = 1'b0;
      for (int c = 0; c < 48; c++) begin
         if (c == 7) chk("R11", "pix_x kept width", int'(pix_x), 7);
         if (c == 8) begin
            chk("R11", "pix_x wrap", int'(pix_x), 0);
            chk("R11", "pix_y wrap", int'(pix_y), 1);
         end
         if (c == 30) begin
            chk("R9", "status before clear", int'(vbl_status), 1);
            vbl_clr = 1'b1;
         end
         if (c == 31) begin
            vbl_clr = 1'b0;
            chk("R9", "status after clear", int'(vbl_status), 0);
            chk("R10", "irq after clear", int'(vbl_irq), 0);
         end
         tick();
      end
      chk("R8", "stopped after last frame", int'(en_status), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule